// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation miss. It takes a 32-bit virtual address and the current table-base register, then walks a two-level page table through a single memory read port. The virtual address is split into three fields: a 12-bit directory index at the top (bits 31:20), a 10-bit leaf index (bits 19:10) and a 10-bit page offset (bits 9:0). Pages are therefore 1 KB. Each leaf table has 1024 four-byte entries and covers 1 MB of virtual space.

The walk reads the directory entry first. If that entry marks its 1 MB region as unmapped, the walk stops at once and reports a hole fault. It does not issue a second read. Otherwise the walk reads the leaf entry. It then returns either the frame number and flag bits, or a not-present fault. Every result carries the virtual page number. The memory port uses a valid/ready request channel and a response strobe with any latency, and the walker holds its state until the response arrives. Only one walk is in flight at a time.

Entry layout: a directory entry has a present bit in bit 0 and the leaf table pointer in bits 31:12, so leaf tables are 4 KB aligned. A leaf entry has the frame number in bits 31:10 and flags in bits 7:0. Bit 0 of the flags is the valid bit. The remaining flag bits (permissions, access, dirty) pass through unchanged.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_req_valid` and `res_valid` are 0. `mem_req_valid` is never high while `req_ready` is high.
- R2: The first read of a walk uses address `req_base + vaddr[31:20]*4`.
- R3: The second read uses address `{dir_entry[31:12], vaddr[19:10], 2'b00}`. Bits 11:1 of the directory entry have no effect on this address.
- R4: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays high and its address does not change.
- R5: The walker waits for each response for any number of cycles. A result appears only after every read of the walk has been answered.
- R6: A directory entry with bit 0 = 0 ends the walk after exactly one read. The result has `res_code` = 1 (hole), and `res_frame` and `res_flags` are 0. The other bits of that entry have no effect.
- R7: A leaf entry with bit 0 = 0 gives `res_code` = 2 (not present), with `res_frame` and `res_flags` set to 0, after exactly two reads.
- R8: A leaf entry with bit 0 = 1 gives `res_code` = 0, `res_frame` = entry[31:10] and `res_flags` = entry[7:0]. Every result reports `res_vpn` = vaddr[31:10].
- R9: `req_ready` is low from the cycle after a request is accepted until the result. A `req_valid` pulse during a walk is ignored and does not start another walk.
- R10: `res_valid` is high for exactly one cycle per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address that missed |
| req_base | input | 32 | Directory base address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 ok, 1 hole, 2 not present |
| res_frame | output | 22 | Physical frame number |
| res_flags | output | 8 | Leaf entry flag bits |
| res_vpn | output | 22 | Virtual page number of the walk |

## Verification
Two situations are hard to reach from the ports. The first is a new miss strobe that arrives while a walk is still waiting on memory. The bench stretches memory latency, pulses `req_valid` with a different address in the middle of the walk, and then confirms that only the first walk's reads and result appear. The second is a hole fault that must not issue a second read. The bench's memory model logs every accepted address and counts responses. Hole walks are then checked for exactly one read, and that includes a directory entry whose pointer bits are non-zero but whose present bit is clear. Varying the ready and response delays covers the hold-until-response behaviour at both levels.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_BITS    = 32,
  parameter int DIR_BITS   = 12,
  parameter int LEAF_BITS  = 10,
  parameter int FLAG_BITS  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [VA_BITS-1:0]            req_vaddr,
  input  logic [VA_BITS-1:0]            req_base,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic [VA_BITS-1:0]            mem_req_addr,
  input  logic                          mem_rsp_valid,
  input  logic [VA_BITS-1:0]            mem_rsp_data,
  output logic                          res_valid,
  output logic [1:0]                    res_code,
  output logic [DIR_BITS+LEAF_BITS-1:0] res_frame,
  output logic [FLAG_BITS-1:0]          res_flags,
  output logic [DIR_BITS+LEAF_BITS-1:0] res_vpn
);
  localparam int OFS_BITS = VA_BITS - DIR_BITS - LEAF_BITS;
  localparam int VPN_BITS = DIR_BITS + LEAF_BITS;
  localparam int PTR_LO   = LEAF_BITS + 2;
  localparam int PTR_BITS = VA_BITS - PTR_LO;
  localparam logic [1:0] CODE_OK     = 2'd0;
  localparam logic [1:0] CODE_HOLE   = 2'd1;
  localparam logic [1:0] CODE_ABSENT = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_LEAF_REQ, S_LEAF_WAIT
  } state_t;

  state_t                st;
  logic [VA_BITS-1:0]    va_q;
  logic [VA_BITS-1:0]    base_q;
  logic [PTR_BITS-1:0]   ptr_q;

  wire [DIR_BITS-1:0]  dir_idx  = va_q[VA_BITS-1 -: DIR_BITS];
  wire [LEAF_BITS-1:0] leaf_idx = va_q[OFS_BITS +: LEAF_BITS];
  wire [VA_BITS-1:0]   dir_addr = base_q + VA_BITS'({dir_idx, 2'b00});
  wire [VA_BITS-1:0]   leaf_addr = {ptr_q, leaf_idx, 2'b00};
  wire                 entry_ok = mem_rsp_data[0];

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DIR_REQ) || (st == S_LEAF_REQ);
  assign mem_req_addr  = (st == S_LEAF_REQ) ? leaf_addr : dir_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      ptr_q     <= '0;
      res_valid <= 1'b0;
      res_code  <= CODE_OK;
      res_frame <= '0;
      res_flags <= '0;
      res_vpn   <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_vaddr;
          base_q <= req_base;
          st     <= S_DIR_REQ;
        end
        S_DIR_REQ: if (mem_req_ready) st <= S_DIR_WAIT;
        S_DIR_WAIT: if (mem_rsp_valid) begin
          if (entry_ok) begin
            ptr_q <= mem_rsp_data[VA_BITS-1:PTR_LO];
            st    <= S_LEAF_REQ;
          end else begin
            res_valid <= 1'b1;
            res_code  <= CODE_HOLE;
            res_frame <= '0;
            res_flags <= '0;
            res_vpn   <= va_q[VA_BITS-1:OFS_BITS];
            st        <= S_IDLE;
          end
        end
        S_LEAF_REQ: if (mem_req_ready) st <= S_LEAF_WAIT;
        S_LEAF_WAIT: if (mem_rsp_valid) begin
          res_valid <= 1'b1;
          res_vpn   <= va_q[VA_BITS-1:OFS_BITS];
          if (entry_ok) begin
            res_code  <= CODE_OK;
            res_frame <= mem_rsp_data[VA_BITS-1:OFS_BITS];
            res_flags <= mem_rsp_data[FLAG_BITS-1:0];
          end else begin
            res_code  <= CODE_ABSENT;
            res_frame <= '0;
            res_flags <= '0;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_vaddr,
  input logic [31:0] req_base,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic [31:0] mem_rsp_data,
  input logic        res_valid,
  input logic [1:0]  res_code,
  input logic [21:0] res_frame,
  input logic [7:0]  res_flags,
  input logic [21:0] res_vpn
);
  logic [1:0]  reads;
  logic [31:0] cap_va;
  logic [31:0] cap_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reads    <= '0;
      cap_va   <= '0;
      cap_base <= '0;
    end else if (req_valid && req_ready) begin
      reads    <= '0;
      cap_va   <= req_vaddr;
      cap_base <= req_base;
    end else if (mem_req_valid && mem_req_ready) begin
      reads <= reads + 2'd1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);  // R1
  AST_DIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && reads == 2'd0) |-> mem_req_addr == cap_base + {18'd0, cap_va[31:20], 2'b00});  // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));  // R4
  AST_HOLE_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code == 2'd1) |-> reads == 2'd1);  // R6
  AST_LEAF_TWO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_code != 2'd1) |-> reads == 2'd2);  // R7
  AST_RES_VPN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_vpn == cap_va[31:10]);  // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);  // R9
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);  // R10
endmodule

bind pt_walker pt_walker_chk chk (.*);

// File: tb/pt_walker_test.sv
module pt_walker_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic [1:0]  res_code;
  logic [21:0] res_frame;
  logic [7:0]  res_flags;
  logic [21:0] res_vpn;

  int total = 0;
  int bad = 0;
  int ready_delay = 0;
  int rsp_delay = 0;
  int n_reads = 0;
  int n_rsps = 0;
  logic [31:0] log_addr [0:7];

  pt_walker uut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mem_lookup(logic [31:0] a);
    case (a)
      32'h0001_000C: return 32'h0020_0001;
      32'h0001_0010: return 32'h0030_0000;
      32'h0020_0554: return 32'h048D_1437;
      32'h0020_0FFC: return 32'h0ABC_D0F6;
      32'h8000_3FFC: return 32'hFFFF_FFFF;
      32'hFFFF_F000: return 32'hFFFF_FC01;
      default:       return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a0;
        a0 = mem_req_addr;
        for (int i = 0; i < ready_delay; i++) begin
          @(negedge clk);
          check("R4", "held request", {31'd0, mem_req_valid}, 32'd1);
          check("R4", "held address", mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        log_addr[n_reads % 8] = mem_req_addr;
        n_reads++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        for (int i = 0; i < rsp_delay; i++) begin
          @(negedge clk);
          check("R5", "early result", {31'd0, res_valid}, 32'd0);
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_lookup(a0);
        n_rsps++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = '0;
      end
    end
  end

  task automatic run_walk(string tag, logic [31:0] base, logic [31:0] va, int rdly, int pdly,
                          logic [1:0] ecode, logic [21:0] eframe, logic [7:0] eflags, int ereads);
    logic [31:0] a0;
    logic [31:0] a1;
    int waited;
    a0 = base + {18'd0, va[31:20], 2'b00};
    a1 = {mem_lookup(a0)[31:12], va[19:10], 2'b00};
    ready_delay = rdly;
    rsp_delay = pdly;
    n_reads = 0;
    n_rsps = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
    check("R9", "busy after accept", {31'd0, req_ready}, 32'd0);
    waited = 0;
    while (!res_valid && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    if (!res_valid) begin
      total++;
      bad++;
      $display("FAIL %s walk timeout: actual=none expected=result", tag);
      return;
    end
    check("R5", "responses before result", n_rsps, ereads);
    check(tag, "code", {30'd0, res_code}, {30'd0, ecode});
    check(tag, "frame", {10'd0, res_frame}, {10'd0, eframe});
    check(tag, "flags", {24'd0, res_flags}, {24'd0, eflags});
    check("R8", "vpn", {10'd0, res_vpn}, {10'd0, va[31:10]});
    check(tag, "read count", n_reads, ereads);
    check("R2", "directory address", log_addr[0], a0);
    if (ereads == 2) check("R3", "leaf address", log_addr[1], a1);
    @(negedge clk);
    check("R10", "result pulse", {31'd0, res_valid}, 32'd0);
    check("R9", "ready after result", {31'd0, req_ready}, 32'd1);
  endtask

  task automatic busy_ignore();
    int waited;
    int seen;
    ready_delay = 2;
    rsp_delay = 4;
    n_reads = 0;
    n_rsps = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 32'h0035_54AB;
    req_base = 32'h0001_0000;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = 32'h7FF0_0000;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!res_valid && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    check("R9", "first walk result code", {30'd0, res_code}, 32'd0);
    check("R9", "first walk vpn", {10'd0, res_vpn}, 32'h0000_0D55);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (res_valid) seen++;
    end
    check("R9", "no second walk reads", n_reads, 2);
    check("R9", "no second result", seen, 0);
  endtask

  initial begin
    #(PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready at reset", {31'd0, req_ready}, 32'd1);
    check("R1", "no memory request", {31'd0, mem_req_valid}, 32'd0);
    check("R1", "no result", {31'd0, res_valid}, 32'd0);

    run_walk("R8", 32'h0001_0000, 32'h0035_54AB, 0, 0, 2'd0, 22'h12345, 8'h37, 2);
    run_walk("R8", 32'h0001_0000, 32'h0035_54AB, 3, 5, 2'd0, 22'h12345, 8'h37, 2);
    run_walk("R6", 32'h0001_0000, 32'h7FF0_0000, 0, 2, 2'd1, 22'h0, 8'h0, 1);
    run_walk("R6", 32'h0001_0000, 32'h0040_0000, 2, 0, 2'd1, 22'h0, 8'h0, 1);
    run_walk("R7", 32'h0001_0000, 32'h003F_FC00, 1, 3, 2'd2, 22'h0, 8'h0, 2);
    run_walk("R3", 32'h8000_0000, 32'hFFF0_03FF, 4, 1, 2'd0, 22'h3FFFFF, 8'h01, 2);
    busy_ignore();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule